// File: doc/BRIEF.md
# Breaker-Failure Trip Release Supervisor

This block sits between the trip command logic of a breaker-failure protection unit and its trip relays. It takes three binary signals from the main protection relay: an external block, a general trip and a general fault detection. From them it forms three release levels. Two of these levels gate the two relays that need an extra hardware release. The first gated relay trips the bus-bar breakers and requires the general trip. The second sends the remote intertrip and does not need the general trip, so it still works when only an end-fault condition is present. The other three relays are driven by the commanded trip bits and the common arm (dual-channel) enable alone.

The block also checks its own releases for plausibility. A release that is present while no phase initiation is active points to an internal fault. A timer counts millisecond ticks while that condition persists. When the timer reaches a programmable delay, and the supervision enable is set, an internal blocking latch is set. A current-sum monitor fault sets the same latch directly. While the latch is set, every release is forced low. The latch is cleared only by reset or by an explicit clear pulse. The actual release levels are reported on a status output, so the processor can compare them with what it commanded.

All pins are plain control and status levels. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bfr_trip_release`

## Requirements
- R1: The intertrip release `rel_sts[2]` is 1 exactly when `fault_det` is 1, `ext_block` is 0 and `int_block` is 0. The output is combinational and reacts in the same cycle.
- R2: The bus-bar release `rel_sts[1]` and the readback release `rel_sts[0]` both equal `rel_sts[2]` AND `gen_trip`.
- R3: `relay_drive[0]` (bus-bar trip) = `trip_cmd[0]` & `relay_arm` & `rel_sts[1]`. `relay_drive[1]` (intertrip) = `trip_cmd[1]` & `relay_arm` & `rel_sts[2]`, so it does not depend on `gen_trip`.
- R4: `relay_drive[i]` for i = 2..4 equals `trip_cmd[i]` & `relay_arm`. These bits are unaffected by the releases and by `int_block`.
- R5: A release fault exists when `fault_det` & ~`ext_block` is 1 (the raw release, taken before any blocking) and `phase_init` == 0. The timer counts `ms_tick` pulses while the fault exists. In the cycle after the count reaches `blk_delay`, `int_block` becomes 1, but only if `blk_enable` is 1. With a delay of 0, `int_block` is set in the cycle after the fault appears.
- R6: If the release fault is absent for any cycle, the tick count restarts from zero.
- R7: `sum_mon_fault` = 1 sets `int_block` at the next clock edge, whatever the value of `blk_enable`.
- R8: Once set, `int_block` stays 1 until `rst` or a `blk_clear` pulse. When a set condition and `blk_clear` occur in the same cycle, the set condition wins.
- R9: While `int_block` is 1, all three release bits and `relay_drive[1:0]` are 0.
- R10: After a synchronous reset, `int_block` is 0 and the tick count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ext_block | input | 1 | External blocking from main protection |
| gen_trip | input | 1 | General trip from main protection |
| fault_det | input | 1 | General fault detection from main protection |
| phase_init | input | 3 | Per-phase initiation, L1..L3 |
| sum_mon_fault | input | 1 | Current-sum monitor fault |
| blk_enable | input | 1 | Enable for the delayed plausibility blocking (1 = yes) |
| blk_delay | input | 16 | Blocking delay in ticks |
| blk_clear | input | 1 | Clear pulse for the blocking latch |
| relay_arm | input | 1 | Common dual-channel relay enable |
| trip_cmd | input | 5 | Commanded trip per relay |
| relay_drive | output | 5 | Relay coil drive |
| rel_sts | output | 3 | Actual release levels {intertrip, bus-bar, readback} |
| int_block | output | 1 | Internal blocking latch |

## Verification
The bench sweeps every combination of the three main-protection inputs, the arm and the five trip commands, both with the latch clear and with it set. A design that tied the intertrip release to the general trip fails this sweep, and so does one that let blocking leak into the three ungated relays. The timer is tested with delays from 0 to 4 and tick counts on both sides of each delay. This catches the off-by-one errors a faulty comparator would show. Further tests cover a count that is dropped and resumed and must not accumulate, and a phase initiation that must mask the fault. They also cover a clear pulse that arrives while the monitor fault is still present, where the latch must stay set.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  localparam int unsigned NUM_RELAYS  = 5;
  localparam int unsigned GATED_RELAY = 2;
  localparam int unsigned NUM_PHASES  = 3;
  localparam int unsigned TMR_W       = 16;

  typedef struct packed {
    logic inter;   // intertrip release
    logic busbar;  // bus-bar release
    logic rdback;  // readback release
  } rel_t;
endpackage

// File: rtl/bfr_release_logic.sv
module bfr_release_logic
  import bfr_pkg::*;
#(
  parameter int unsigned NPH = NUM_PHASES
) (
  input  logic           ext_block,
  input  logic           gen_trip,
  input  logic           fault_det,
  input  logic [NPH-1:0] phase_init,
  input  logic           blocked,
  output rel_t           rel_out,
  output logic           rel_fault
);
  rel_t raw;

  always_comb begin
    raw.inter  = fault_det & ~ext_block;
    raw.busbar = raw.inter & gen_trip;
    raw.rdback = raw.inter & gen_trip;
  end

  // plausibility uses the ungated levels so blocking cannot mask the fault
  assign rel_fault = (|raw) && (phase_init == '0);
  assign rel_out   = blocked ? '0 : raw;
endmodule

// File: rtl/bfr_fault_timer.sv
module bfr_fault_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cond,
  input  logic [W-1:0] delay,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cond)
      cnt <= '0;
    else if (tick && (cnt < delay))
      cnt <= cnt + 1'b1;
  end

  assign expired = cond && (cnt >= delay);
endmodule

// File: rtl/bfr_block_latch.sv
module bfr_block_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic expired,
  input  logic mon_fault,
  input  logic clear,
  output logic q
);
  logic set_req;
  assign set_req = (enable && expired) || mon_fault;

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (set_req) q <= 1'b1;
    else if (clear)   q <= 1'b0;
  end
endmodule

// File: rtl/bfr_relay_gate.sv
module bfr_relay_gate #(
  parameter int unsigned N = 5,
  parameter int unsigned G = 2
) (
  input  logic         arm,
  input  logic [N-1:0] cmd,
  input  logic [G-1:0] gate,
  output logic [N-1:0] drive
);
  for (genvar i = 0; i < N; i++) begin : g_relay
    if (i < G) begin : g_gated
      assign drive[i] = cmd[i] & arm & gate[i];
    end else begin : g_plain
      assign drive[i] = cmd[i] & arm;
    end
  end
endmodule

// File: rtl/bfr_trip_release.sv
module bfr_trip_release
  import bfr_pkg::*;
#(
  parameter int unsigned NRLY = NUM_RELAYS,
  parameter int unsigned NPH  = NUM_PHASES,
  parameter int unsigned TW   = TMR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ms_tick,
  input  logic            ext_block,
  input  logic            gen_trip,
  input  logic            fault_det,
  input  logic [NPH-1:0]  phase_init,
  input  logic            sum_mon_fault,
  input  logic            blk_enable,
  input  logic [TW-1:0]   blk_delay,
  input  logic            blk_clear,
  input  logic            relay_arm,
  input  logic [NRLY-1:0] trip_cmd,
  output logic [NRLY-1:0] relay_drive,
  output logic [2:0]      rel_sts,
  output logic            int_block
);
  localparam int unsigned G = GATED_RELAY;

  rel_t         rel;
  logic         rel_fault;
  logic         expired;
  logic [G-1:0] gate;

  bfr_release_logic #(.NPH(NPH)) u_rel (
    .ext_block (ext_block),
    .gen_trip  (gen_trip),
    .fault_det (fault_det),
    .phase_init(phase_init),
    .blocked   (int_block),
    .rel_out   (rel),
    .rel_fault (rel_fault)
  );

  bfr_fault_timer #(.W(TW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .tick   (ms_tick),
    .cond   (rel_fault),
    .delay  (blk_delay),
    .expired(expired)
  );

  bfr_block_latch u_blk (
    .clk      (clk),
    .rst      (rst),
    .enable   (blk_enable),
    .expired  (expired),
    .mon_fault(sum_mon_fault),
    .clear    (blk_clear),
    .q        (int_block)
  );

  assign gate = {rel.inter, rel.busbar};

  bfr_relay_gate #(.N(NRLY), .G(G)) u_gate (
    .arm  (relay_arm),
    .cmd  (trip_cmd),
    .gate (gate),
    .drive(relay_drive)
  );

  assign rel_sts = rel;
endmodule

// File: rtl/bfr_trip_release_chk.sv
module bfr_trip_release_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_block,
  input logic       fault_det,
  input logic       sum_mon_fault,
  input logic       blk_enable,
  input logic       blk_clear,
  input logic       relay_arm,
  input logic [4:0] relay_drive,
  input logic [2:0] rel_sts,
  input logic       int_block
);
  // R1
  intertrip_cond_chk: assert property (@(posedge clk) disable iff (rst)
    rel_sts[2] |-> (fault_det && !ext_block));
  // R2
  busbar_needs_inter_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_sts[1] || rel_sts[0]) |-> rel_sts[2]);
  // R4
  no_arm_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !relay_arm |-> (relay_drive == 5'b0));
  // R7
  mon_sets_block_chk: assert property (@(posedge clk) disable iff (rst)
    sum_mon_fault |=> int_block);
  // R8
  block_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (int_block && !blk_clear) |=> int_block);
  // R5
  block_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_block) |-> $past(sum_mon_fault || blk_enable));
  // R9
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    int_block |-> (rel_sts == 3'b0 && relay_drive[1:0] == 2'b0));
endmodule

bind bfr_trip_release bfr_trip_release_chk u_chk (
  .clk(clk), .rst(rst), .ext_block(ext_block), .fault_det(fault_det),
  .sum_mon_fault(sum_mon_fault), .blk_enable(blk_enable), .blk_clear(blk_clear),
  .relay_arm(relay_arm), .relay_drive(relay_drive), .rel_sts(rel_sts),
  .int_block(int_block)
);

// File: tb/bfr_trip_release_tb.sv
module bfr_trip_release_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, ms_tick, ext_block, gen_trip, fault_det;
  logic [2:0]  phase_init;
  logic        sum_mon_fault, blk_enable, blk_clear, relay_arm;
  logic [15:0] blk_delay;
  logic [4:0]  trip_cmd, relay_drive;
  logic [2:0]  rel_sts;
  logic        int_block;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bfr_trip_release u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .ext_block(ext_block),
    .gen_trip(gen_trip), .fault_det(fault_det), .phase_init(phase_init),
    .sum_mon_fault(sum_mon_fault), .blk_enable(blk_enable),
    .blk_delay(blk_delay), .blk_clear(blk_clear), .relay_arm(relay_arm),
    .trip_cmd(trip_cmd), .relay_drive(relay_drive), .rel_sts(rel_sts),
    .int_block(int_block)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; ms_tick = 0; ext_block = 0; gen_trip = 0; fault_det = 0;
    phase_init = 3'b111; sum_mon_fault = 0; blk_enable = 0; blk_clear = 0;
    relay_arm = 0; trip_cmd = 0; blk_delay = 0;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step(); ms_tick = 1'b0;
    end
  endtask

  // sweep all release inputs, arm and commands; blk is the latch state held
  task automatic sweep(input logic blk);
    for (int v = 0; v < 512; v++) begin
      logic ex, tr, fd, arm, r2, r1;
      logic [4:0] cmd, exp_drv;
      {ex, tr, fd, arm, cmd} = v[8:0];
      ext_block = ex; gen_trip = tr; fault_det = fd; relay_arm = arm; trip_cmd = cmd;
      #1;
      r2 = fd & ~ex & ~blk;
      r1 = r2 & tr;
      exp_drv[0] = cmd[0] & arm & r1;
      exp_drv[1] = cmd[1] & arm & r2;
      exp_drv[4:2] = cmd[4:2] & {3{arm}};
      chk(blk ? "R9 releases" : "R1/R2 releases", {5'b0, rel_sts}, {5'b0, r2, r1, r1});
      chk(blk ? "R9/R4 drive" : "R3/R4 drive", {3'b0, relay_drive}, {3'b0, exp_drv});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10 int_block after reset", {7'b0, int_block}, 8'h0);
    chk("R10 rel after reset", {5'b0, rel_sts}, 8'h0);

    // R1 R2 R3 R4: full sweep with latch clear
    sweep(1'b0);

    // R5 R10: delay vs tick count
    for (int d = 0; d <= 4; d++) begin
      for (int n = 0; n <= 5; n++) begin
        do_reset();
        blk_delay = 16'(d); blk_enable = 1; phase_init = 0; fault_det = 1;
        tick_n(n);
        step();
        chk($sformatf("R5 delay %0d ticks %0d", d, n), {7'b0, int_block},
            {7'b0, (n >= d)});
      end
    end

    // R6: interrupted count does not accumulate
    do_reset();
    blk_delay = 3; blk_enable = 1; phase_init = 0; fault_det = 1;
    tick_n(2);
    fault_det = 0; step(); fault_det = 1;
    tick_n(2); step();
    chk("R6 restart no block", {7'b0, int_block}, 8'h0);
    tick_n(1); step();
    chk("R6 block after full delay", {7'b0, int_block}, 8'h1);

    // R5: a phase initiation masks the fault
    for (int p = 1; p < 8; p++) begin
      do_reset();
      blk_delay = 0; blk_enable = 1; phase_init = 3'(p); fault_det = 1; gen_trip = 1;
      tick_n(3); step();
      chk($sformatf("R5 phase %0d masks", p), {7'b0, int_block}, 8'h0);
    end

    // R5: supervision disabled
    do_reset();
    blk_delay = 0; blk_enable = 0; phase_init = 0; fault_det = 1;
    tick_n(5); step();
    chk("R5 disabled no block", {7'b0, int_block}, 8'h0);

    // R7: monitor fault sets latch with supervision disabled
    fault_det = 0; sum_mon_fault = 1; step(); sum_mon_fault = 0;
    chk("R7 monitor sets", {7'b0, int_block}, 8'h1);

    // R8: holds without clear
    for (int i = 0; i < 10; i++) step();
    chk("R8 holds", {7'b0, int_block}, 8'h1);

    // R9 R4: sweep with latch set
    phase_init = 3'b111;
    sweep(1'b1);

    // R8: clear loses against active monitor fault
    sum_mon_fault = 1; blk_clear = 1; step();
    chk("R8 set wins over clear", {7'b0, int_block}, 8'h1);
    sum_mon_fault = 0; step(); blk_clear = 0;
    chk("R8 clear", {7'b0, int_block}, 8'h0);
    step();
    chk("R8 stays clear", {7'b0, int_block}, 8'h0);

    // R8: reset clears
    sum_mon_fault = 1; step(); sum_mon_fault = 0;
    rst = 1; step(); rst = 0;
    chk("R8 reset clears", {7'b0, int_block}, 8'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule